// File: doc/BRIEF.md
# Leg and Clamp Gate Dead-Time Guard

This block sits between a modulator and the gate drivers of a three-phase two-level bridge that also has one midpoint clamp switch. The modulator issues ideal on/off commands for the upper and lower switch of each leg and for the clamp. The block turns these into gate drives that never overlap. An upper and a lower switch of the same leg are separated by a leg dead-time. Any handover between a leg switch and the clamp is separated by a clamp dead-time. Both dead-times are loaded as clock-cycle counts. The clamp dead-time is normally the larger one, because leg devices switch off more slowly than the clamp switches on. A single output drives the whole clamp.

Each of the seven switches has its own small state machine with three states. In `SW_OFF` the command is low. In `SW_WAIT` the command is high but the required quiet time has not yet elapsed. In `SW_ON` the gate is driven. The transitions are named as follows. *arm* (`SW_OFF`→`SW_WAIT`) is taken when a request arrives before its window has elapsed. *fire* (`SW_OFF`→`SW_ON` or `SW_WAIT`→`SW_ON`) is taken when the request is present and the window has elapsed. *drop* (`SW_WAIT`→`SW_OFF` or `SW_ON`→`SW_OFF`) is taken as soon as the request is withdrawn. Each switch also counts how long its gate has been low, saturating at the counter maximum. The permit for every other switch is derived from these counts.

Requests that contradict each other are refused. A sticky fault flag records that this happened.

Top module: `gate_deadtime_guard`

## Requirements
- R1: While reset is asserted and in the first cycle after it, all seven gate outputs and the fault flag are low.
- R2: With a leg dead-time of D, an upper (lower) gate whose command is held rises exactly max(D,1) clock cycles after the edge on which the opposite gate of the same leg fell, provided the clamp window is also satisfied.
- R3: After reset every low-time count starts saturated, so a lone command that is not in conflict drives its gate high on the first clock edge that samples it.
- R4: Falling is never delayed: a gate goes low on the first clock edge that samples its command low.
- R5: With a clamp dead-time of C, a held clamp command drives the clamp gate high exactly max(C,1) cycles after the edge on which the last of the six leg gates fell.
- R6: After the clamp gate falls, a held leg command raises its gate exactly max(C,1) cycles later, provided the leg window is already satisfied.
- R7: Commanding the upper and lower switch of the same leg together drives both of that leg's gates low on the next edge and sets the fault flag; the other legs are unaffected.
- R8: Commanding the clamp together with any leg switch drives the clamp gate and all six leg gates low on the next edge and sets the fault flag.
- R9: Once set, the fault flag stays high until reset.
- R10: The upper and lower gate of a leg are never high together, the clamp gate is never high together with any leg gate, and every output follows the cycle rules above for any command sequence.
- R11: A gate that is high stays high for as long as its command stays high without conflict, even if a dead-time value changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_up | input | NLEG | Ideal upper-switch commands, bit i is leg i |
| cmd_dn | input | NLEG | Ideal lower-switch commands, bit i is leg i |
| cmd_mid | input | 1 | Ideal clamp command |
| leg_dead | input | CW | Leg dead-time in clock cycles (0 acts as 1) |
| mid_dead | input | CW | Clamp dead-time in clock cycles (0 acts as 1) |
| gate_up | output | NLEG | Upper gate drives |
| gate_dn | output | NLEG | Lower gate drives |
| gate_mid | output | 1 | Clamp gate drive |
| fault | output | 1 | Sticky conflict flag |

## Verification
The bench uses the default build of three legs with 8-bit counts. At run time it loads a leg dead-time of 3 and a clamp dead-time of 5, and later 0 for both. The first pair makes the asymmetric clamp window directly measurable against the shorter leg window. The zero pair reaches the one-cycle floor. Because the counts start saturated at 255 after each reset, both the first-request path and the saturation ceiling come into play. Random command patterns, including contradictory ones, run against a cycle model built from the requirements, with periodic resets that clear the fault flag.

// File: rtl/dtg_pkg.sv
package dtg_pkg;

    // Per-switch gate state
    typedef enum logic [1:0] {
        SW_OFF  = 2'd0,
        SW_WAIT = 2'd1,
        SW_ON   = 2'd2
    } sw_state_t;

endpackage

// File: rtl/dtg_switch_fsm.sv
module dtg_switch_fsm
    import dtg_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  logic          permit,
    output logic          gate,
    output logic [CW-1:0] low_cnt
);

    localparam logic [CW-1:0] CNT_SAT = '1;

    sw_state_t st_q;
    sw_state_t st_d;

    // next-state: arm, fire, drop
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            SW_OFF: begin
                if (req) begin
                    st_d = permit ? SW_ON : SW_WAIT;
                end
            end
            SW_WAIT: begin
                if (!req) begin
                    st_d = SW_OFF;
                end else if (permit) begin
                    st_d = SW_ON;
                end
            end
            SW_ON: begin
                if (!req) begin
                    st_d = SW_OFF;
                end
            end
            default: st_d = SW_OFF;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= SW_OFF;
        end else begin
            st_q <= st_d;
        end
    end

    // outputs
    always_comb begin
        gate = (st_q == SW_ON);
    end

    // time spent with the gate low, saturating
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_cnt <= CNT_SAT;
        end else if (st_d == SW_ON) begin
            low_cnt <= '0;
        end else if (low_cnt != CNT_SAT) begin
            low_cnt <= low_cnt + 1'b1;
        end
    end

    AST_FALL_NOW: assert property (@(posedge clk) disable iff (!rst_n)
        !req |=> !gate); // R4

    AST_HOLD_ON: assert property (@(posedge clk) disable iff (!rst_n)
        (gate && req) |=> gate); // R11

endmodule

// File: rtl/dtg_conflict.sv
module dtg_conflict #(
    parameter int NLEG = 3
) (
    input  logic [NLEG-1:0] cmd_up,
    input  logic [NLEG-1:0] cmd_dn,
    input  logic            cmd_mid,
    output logic [NLEG-1:0] req_up,
    output logic [NLEG-1:0] req_dn,
    output logic            req_mid,
    output logic            hit
);

    logic [NLEG-1:0] leg_clash;
    logic            mid_clash;

    always_comb begin
        mid_clash = cmd_mid && ((|cmd_up) || (|cmd_dn));
        req_mid   = cmd_mid && !mid_clash;
        hit       = mid_clash || (|leg_clash);
    end

    for (genvar i = 0; i < NLEG; i++) begin : g_leg
        always_comb begin
            leg_clash[i] = cmd_up[i] && cmd_dn[i];
            req_up[i]    = cmd_up[i] && !leg_clash[i] && !mid_clash;
            req_dn[i]    = cmd_dn[i] && !leg_clash[i] && !mid_clash;
        end
    end

endmodule

// File: rtl/dtg_permit.sv
module dtg_permit #(
    parameter int NLEG = 3,
    parameter int CW   = 8
) (
    input  logic [CW-1:0]           leg_dead,
    input  logic [CW-1:0]           mid_dead,
    input  logic [NLEG-1:0][CW-1:0] up_low,
    input  logic [NLEG-1:0][CW-1:0] dn_low,
    input  logic [CW-1:0]           mid_low,
    output logic [NLEG-1:0]         permit_up,
    output logic [NLEG-1:0]         permit_dn,
    output logic                    permit_mid
);

    localparam logic [CW-1:0] ONE = {{(CW-1){1'b0}}, 1'b1};

    logic [CW-1:0] leg_need;
    logic [CW-1:0] mid_need;
    logic          mid_quiet;
    logic          legs_quiet;

    // a zero setting still leaves one cycle of gap
    always_comb begin
        leg_need  = (leg_dead == '0) ? ONE : leg_dead;
        mid_need  = (mid_dead == '0) ? ONE : mid_dead;
        mid_quiet = (mid_low >= mid_need);
    end

    always_comb begin
        legs_quiet = 1'b1;
        for (int i = 0; i < NLEG; i++) begin
            if ((up_low[i] < mid_need) || (dn_low[i] < mid_need)) begin
                legs_quiet = 1'b0;
            end
        end
        permit_mid = legs_quiet;
    end

    for (genvar i = 0; i < NLEG; i++) begin : g_leg
        always_comb begin
            permit_up[i] = (dn_low[i] >= leg_need) && mid_quiet;
            permit_dn[i] = (up_low[i] >= leg_need) && mid_quiet;
        end
    end

endmodule

// File: rtl/dtg_fault_latch.sv
module dtg_fault_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    output logic fault
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fault <= 1'b0;
        end else if (hit) begin
            fault <= 1'b1;
        end
    end

    AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> fault); // R9

endmodule

// File: rtl/gate_deadtime_guard.sv
module gate_deadtime_guard #(
    parameter int NLEG = 3,
    parameter int CW   = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NLEG-1:0] cmd_up,
    input  logic [NLEG-1:0] cmd_dn,
    input  logic            cmd_mid,
    input  logic [CW-1:0]   leg_dead,
    input  logic [CW-1:0]   mid_dead,
    output logic [NLEG-1:0] gate_up,
    output logic [NLEG-1:0] gate_dn,
    output logic            gate_mid,
    output logic            fault
);

    logic [NLEG-1:0]         req_up;
    logic [NLEG-1:0]         req_dn;
    logic                    req_mid;
    logic                    hit;
    logic [NLEG-1:0]         permit_up;
    logic [NLEG-1:0]         permit_dn;
    logic                    permit_mid;
    logic [NLEG-1:0][CW-1:0] up_low;
    logic [NLEG-1:0][CW-1:0] dn_low;
    logic [CW-1:0]           mid_low;

    dtg_conflict #(.NLEG(NLEG)) u_conflict (
        .cmd_up  (cmd_up),
        .cmd_dn  (cmd_dn),
        .cmd_mid (cmd_mid),
        .req_up  (req_up),
        .req_dn  (req_dn),
        .req_mid (req_mid),
        .hit     (hit)
    );

    dtg_permit #(.NLEG(NLEG), .CW(CW)) u_permit (
        .leg_dead   (leg_dead),
        .mid_dead   (mid_dead),
        .up_low     (up_low),
        .dn_low     (dn_low),
        .mid_low    (mid_low),
        .permit_up  (permit_up),
        .permit_dn  (permit_dn),
        .permit_mid (permit_mid)
    );

    for (genvar i = 0; i < NLEG; i++) begin : g_leg
        dtg_switch_fsm #(.CW(CW)) u_up (
            .clk     (clk),
            .rst_n   (rst_n),
            .req     (req_up[i]),
            .permit  (permit_up[i]),
            .gate    (gate_up[i]),
            .low_cnt (up_low[i])
        );

        dtg_switch_fsm #(.CW(CW)) u_dn (
            .clk     (clk),
            .rst_n   (rst_n),
            .req     (req_dn[i]),
            .permit  (permit_dn[i]),
            .gate    (gate_dn[i]),
            .low_cnt (dn_low[i])
        );

        AST_LEG_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
            !(gate_up[i] && gate_dn[i])); // R10

        AST_UP_AFTER_DN: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(gate_up[i]) |-> $past(!gate_dn[i])); // R2

        AST_DN_AFTER_UP: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(gate_dn[i]) |-> $past(!gate_up[i])); // R2

        AST_LEG_CLASH: assert property (@(posedge clk) disable iff (!rst_n)
            (cmd_up[i] && cmd_dn[i]) |=> (!gate_up[i] && !gate_dn[i] && fault)); // R7
    end

    dtg_switch_fsm #(.CW(CW)) u_mid (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (req_mid),
        .permit  (permit_mid),
        .gate    (gate_mid),
        .low_cnt (mid_low)
    );

    dtg_fault_latch u_fault (
        .clk   (clk),
        .rst_n (rst_n),
        .hit   (hit),
        .fault (fault)
    );

    AST_MID_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        gate_mid |-> (gate_up == '0 && gate_dn == '0)); // R10

    AST_MID_AFTER_LEGS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_mid) |-> $past(gate_up == '0 && gate_dn == '0)); // R5

    AST_MID_CLASH: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_mid && (cmd_up != '0 || cmd_dn != '0))
        |=> (!gate_mid && gate_up == '0 && gate_dn == '0 && fault)); // R8

endmodule

// File: tb/gate_deadtime_guard_tb.sv
module gate_deadtime_guard_tb;

    localparam int NLEG = 3;
    localparam int CW   = 8;
    localparam int SAT  = 255;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NLEG-1:0] cmd_up = '0;
    logic [NLEG-1:0] cmd_dn = '0;
    logic            cmd_mid = 1'b0;
    logic [CW-1:0]   leg_dead = 8'd3;
    logic [CW-1:0]   mid_dead = 8'd5;
    logic [NLEG-1:0] gate_up;
    logic [NLEG-1:0] gate_dn;
    logic            gate_mid;
    logic            fault;

    int total = 0;
    int bad   = 0;

    gate_deadtime_guard #(.NLEG(NLEG), .CW(CW)) u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_up   (cmd_up),
        .cmd_dn   (cmd_dn),
        .cmd_mid  (cmd_mid),
        .leg_dead (leg_dead),
        .mid_dead (mid_dead),
        .gate_up  (gate_up),
        .gate_dn  (gate_dn),
        .gate_mid (gate_mid),
        .fault    (fault)
    );

    always #5 clk = ~clk;

    // cycle model built from the requirements
    bit m_up [NLEG];
    bit m_dn [NLEG];
    bit m_mid;
    bit m_fault;
    int c_up [NLEG];
    int c_dn [NLEG];
    int c_mid;

    function automatic int need(input int d);
        return (d == 0) ? 1 : d;
    endfunction

    function automatic int bump(input int c);
        return (c >= SAT) ? SAT : c + 1;
    endfunction

    function automatic logic [7:0] model_vec();
        return {m_up[2], m_up[1], m_up[0], m_dn[2], m_dn[1], m_dn[0], m_mid, m_fault};
    endfunction

    task automatic model_reset();
        for (int i = 0; i < NLEG; i++) begin
            m_up[i] = 0; m_dn[i] = 0; c_up[i] = SAT; c_dn[i] = SAT;
        end
        m_mid = 0; m_fault = 0; c_mid = SAT;
    endtask

    task automatic model_step();
        int ln;
        int cn;
        bit midc;
        bit legc;
        bit quiet;
        bit n_up [NLEG];
        bit n_dn [NLEG];
        bit n_mid;
        ln = need(int'(leg_dead));
        cn = need(int'(mid_dead));
        midc = cmd_mid && (cmd_up != 0 || cmd_dn != 0);
        quiet = 1;
        for (int i = 0; i < NLEG; i++) begin
            if (c_up[i] < cn || c_dn[i] < cn) quiet = 0;
        end
        for (int i = 0; i < NLEG; i++) begin
            legc = cmd_up[i] && cmd_dn[i];
            if (legc) m_fault = 1;
            n_up[i] = cmd_up[i] && !legc && !midc && (m_up[i] || (c_dn[i] >= ln && c_mid >= cn));
            n_dn[i] = cmd_dn[i] && !legc && !midc && (m_dn[i] || (c_up[i] >= ln && c_mid >= cn));
        end
        n_mid = cmd_mid && !midc && (m_mid || quiet);
        if (midc) m_fault = 1;
        for (int i = 0; i < NLEG; i++) begin
            m_up[i] = n_up[i]; c_up[i] = n_up[i] ? 0 : bump(c_up[i]);
            m_dn[i] = n_dn[i]; c_dn[i] = n_dn[i] ? 0 : bump(c_dn[i]);
        end
        m_mid = n_mid; c_mid = n_mid ? 0 : bump(c_mid);
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic pick(input int sel);
        if (sel < 3) return gate_up[sel];
        if (sel < 6) return gate_dn[sel-3];
        return gate_mid;
    endfunction

    task automatic tick(input logic [2:0] u, input logic [2:0] d, input logic m);
        int clash;
        cmd_up = u; cmd_dn = d; cmd_mid = m;
        model_step();
        @(negedge clk);
        chk("R10 model", int'({gate_up, gate_dn, gate_mid, fault}), int'(model_vec()));
        clash = ((gate_up & gate_dn) != 0 || (gate_mid && (gate_up != 0 || gate_dn != 0))) ? 1 : 0;
        if (clash != 0) chk("R10 overlap", clash, 0);
    endtask

    task automatic wait_rise(input logic [2:0] u, input logic [2:0] d, input logic m,
                             input int sel, output int n);
        n = 0;
        while (!pick(sel) && n < 40) begin
            tick(u, d, m);
            n++;
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        cmd_up = '0; cmd_dn = '0; cmd_mid = 1'b0;
        model_reset();
        @(negedge clk);
        chk("R1 gates in reset", int'({gate_up, gate_dn, gate_mid, fault}), 0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic directed();
        int n;
        do_reset();
        chk("R1 gates after reset", int'({gate_up, gate_dn, gate_mid, fault}), 0);
        tick(3'b001, 3'b000, 1'b0);
        chk("R3 first request", int'(gate_up[0]), 1);
        tick(3'b000, 3'b001, 1'b0);
        chk("R4 upper falls", int'(gate_up[0]), 0);
        wait_rise(3'b000, 3'b001, 1'b0, 3, n);
        chk("R2 lower after upper", n, need(int'(leg_dead)));
        tick(3'b000, 3'b000, 1'b0);
        wait_rise(3'b000, 3'b000, 1'b1, 6, n);
        chk("R5 clamp after legs", n, need(int'(mid_dead)));
        tick(3'b010, 3'b000, 1'b0);
        chk("R4 clamp falls", int'(gate_mid), 0);
        wait_rise(3'b010, 3'b000, 1'b0, 1, n);
        chk("R6 leg after clamp", n, need(int'(mid_dead)));
        chk("R9 no fault yet", int'(fault), 0);
        tick(3'b110, 3'b100, 1'b0);
        chk("R7 leg2 both low", int'({gate_up[2], gate_dn[2]}), 0);
        chk("R7 fault set", int'(fault), 1);
        chk("R11 leg1 kept", int'(gate_up[1]), 1);
    endtask

    task automatic clamp_clash();
        do_reset();
        tick(3'b001, 3'b000, 1'b0);
        tick(3'b001, 3'b000, 1'b1);
        chk("R8 all low", int'({gate_up, gate_dn, gate_mid}), 0);
        chk("R8 fault set", int'(fault), 1);
        for (int k = 0; k < 20; k++) tick(3'b000, 3'b000, 1'b0);
        chk("R9 fault held", int'(fault), 1);
    endtask

    task automatic random_run(input int count);
        logic [2:0] u;
        logic [2:0] d;
        logic m;
        int r;
        u = '0; d = '0; m = 1'b0;
        for (int k = 0; k < count; k++) begin
            if (k % 600 == 599) begin
                do_reset();
                u = '0; d = '0; m = 1'b0;
            end
            if ($urandom_range(0, 5) == 0) begin
                r = $urandom_range(0, 9);
                u = '0; d = '0; m = 1'b0;
                if (r >= 2 && r <= 6) begin
                    for (int i = 0; i < NLEG; i++) begin
                        case ($urandom_range(0, 3))
                            1: u[i] = 1'b1;
                            2: d[i] = 1'b1;
                            default: ;
                        endcase
                    end
                end else if (r == 7 || r == 8) begin
                    m = 1'b1;
                end else if (r == 9) begin
                    {u, d, m} = 7'($urandom_range(0, 127));
                end
            end
            tick(u, d, m);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int n;
        void'($urandom(32'd20211));
        leg_dead = 8'd3;
        mid_dead = 8'd5;
        directed();
        clamp_clash();
        do_reset();
        random_run(3000);
        leg_dead = 8'd0;
        mid_dead = 8'd0;
        do_reset();
        tick(3'b001, 3'b000, 1'b0);
        tick(3'b000, 3'b001, 1'b0);
        chk("R2 zero floor lower not yet", int'(gate_dn[0]), 0);
        wait_rise(3'b000, 3'b001, 1'b0, 3, n);
        chk("R2 zero floor", n, 1);
        tick(3'b000, 3'b000, 1'b0);
        wait_rise(3'b000, 3'b000, 1'b1, 6, n);
        chk("R5 zero floor", n, 1);
        do_reset();
        random_run(3000);
        leg_dead = 8'd1;
        mid_dead = 8'd12;
        do_reset();
        random_run(1500);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule